// File: doc/BRIEF.md
# Floating-Point Exception Priority Resolver

This block sits behind a floating-point datapath and turns the raw condition bits the datapath detects for one operation into the architectural outcome. The conditions are a signalling-NaN operand, a quiet-NaN operand, any other invalid operation, division by zero, a denormal operand, overflow, a tiny result and an inexact result. Each operation is presented for one cycle with a valid strobe, together with six mask bits and the two operand signs.

A fixed six-level precedence is applied. Signalling-NaN invalid comes first. A quiet-NaN operand comes second: it is not an exception but it silences everything below it. Other invalid and divide-by-zero share the third level, then denormal operand, then overflow or underflow, then inexact. Pre-operation exceptions (invalid, divide-by-zero, denormal) that are unmasked leave the destination untouched. A masked denormal lets lower levels through. Underflow is reported differently depending on its own mask bit.

The block keeps six sticky status flags and raises a one-cycle trap request when any reported exception is unmasked. It also tells the write-back stage which kind of result to store: the computed value, a QNaN indefinite, a signed infinity, or nothing.

Top module: `fpx_resolver`

## Requirements
- R1: After reset, `status_flags` is 0, `trap_req` is 0, `res_valid` is 0 and `res_kind` is 0.
- R2: Flag and mask bit positions are 0 invalid, 1 denormal, 2 divide-by-zero, 3 overflow, 4 underflow, 5 inexact; a mask bit of 1 masks that exception. On each strobe the reported set is OR-ed into `status_flags`, and no flag ever drops without a clear.
- R3: With `clr_flags` high and no strobe, `status_flags` is 0 in the next cycle. With `clr_flags` and a strobe in the same cycle, the flags become exactly that operation's reported set.
- R4: A signalling-NaN operand reports invalid only. When invalid is masked, `res_kind` is 1 (QNaN indefinite) with no trap. When it is unmasked, a trap is requested and `res_kind` is 3 (keep destination).
- R5: A quiet-NaN operand without a signalling NaN reports nothing, requests no trap, gives `res_kind` 0 (computed) and overrides every lower condition, including divide-by-zero.
- R6: Another invalid operation behaves like R4 and takes priority over divide-by-zero raised in the same operation.
- R7: Divide-by-zero reports the divide-by-zero flag. When masked, `res_kind` is 2 (signed infinity) and `res_sign` is the XOR of the operand signs. When unmasked, a trap is requested and `res_kind` is 3.
- R8: A denormal operand reports the denormal flag. When unmasked, a trap is requested, `res_kind` is 3 and all lower conditions are ignored. When masked, lower levels are still evaluated.
- R9: Overflow reports the overflow flag, plus the inexact flag if the result is inexact, with `res_kind` 0. Overflow overrides a tiny indication.
- R10: When underflow is masked, it is reported only for a result that is both tiny and inexact. When it is unmasked, it is reported for any tiny result. The inexact flag follows inexactness.
- R11: Inexact alone reports the inexact flag with `res_kind` 0. A trap follows whenever any reported flag is unmasked.
- R12: `res_valid`, `res_kind`, `res_sign` and `trap_req` are registered one cycle after the strobe. Without a strobe, `res_valid` and `trap_req` are 0, and `res_kind` and `res_sign` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_flags | input | 1 | Synchronous clear of the sticky flags |
| op_valid | input | 1 | One-cycle strobe, conditions valid |
| cnd_snan | input | 1 | Signalling-NaN operand seen |
| cnd_qnan | input | 1 | Quiet-NaN operand seen |
| cnd_inv_other | input | 1 | Other invalid operation |
| cnd_div_zero | input | 1 | Finite non-zero divided by zero |
| cnd_denorm | input | 1 | Denormal operand seen |
| cnd_overflow | input | 1 | Rounded result overflows |
| cnd_tiny | input | 1 | Result is tiny |
| cnd_inexact | input | 1 | Result is inexact |
| sign_a | input | 1 | Sign of first operand |
| sign_b | input | 1 | Sign of second operand |
| exc_mask | input | 6 | Mask bits, positions as in R2 |
| status_flags | output | 6 | Sticky status flags |
| trap_req | output | 1 | One-cycle trap request |
| res_valid | output | 1 | Result selection valid |
| res_kind | output | 2 | 0 computed, 1 QNaN indefinite, 2 signed infinity, 3 keep destination |
| res_sign | output | 1 | Sign for the signed-infinity result |

## Verification
The hardest situations to reach from the ports are the stacked ones: a signalling NaN or quiet NaN together with divide-by-zero, a masked denormal that must let overflow or inexact through, and a tiny but exact result under both mask settings. Uniform random stimulus would rarely make these with a clean flag state. The stimulus therefore clears the flags and drives each stacked pattern directly with hand-computed outcomes. It then runs a long stretch of biased random conditions and masks, with occasional clears, against a per-clock reference model.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

  localparam int NFLAG = 6;
  localparam int F_INV = 0;
  localparam int F_DEN = 1;
  localparam int F_ZDV = 2;
  localparam int F_OVF = 3;
  localparam int F_UNF = 4;
  localparam int F_PRE = 5;

  typedef enum logic [1:0] {
    RK_COMPUTED   = 2'd0,
    RK_QNAN_INDEF = 2'd1,
    RK_SIGNED_INF = 2'd2,
    RK_KEEP_DEST  = 2'd3
  } res_kind_e;

  typedef struct packed {
    logic [NFLAG-1:0] rep;
    logic             stop;
    res_kind_e        kind;
    logic             sign;
  } pre_out_t;

  // any reported exception whose mask bit is clear
  function automatic logic any_unmasked(input logic [NFLAG-1:0] rep,
                                        input logic [NFLAG-1:0] mask);
    return |(rep & ~mask);
  endfunction

  // sign of the infinity returned for a masked zero divide
  function automatic logic inf_sign(input logic a, input logic b);
    return a ^ b;
  endfunction

  // underflow report rule depends on its own mask bit
  function automatic logic underflow_report(input logic tiny, input logic inexact,
                                            input logic masked);
    return masked ? (tiny & inexact) : tiny;
  endfunction

endpackage

// File: rtl/fpx_pre_resolve.sv
module fpx_pre_resolve
  import fpx_pkg::*;
(
  input  logic     snan,
  input  logic     qnan,
  input  logic     inv_other,
  input  logic     div_zero,
  input  logic     denorm,
  input  logic     m_inv,
  input  logic     m_den,
  input  logic     m_zdv,
  input  logic     sign_a,
  input  logic     sign_b,
  output pre_out_t pre,
  output logic     ev_qnan_block
);

  always_comb begin
    pre       = '0;
    pre.kind  = RK_COMPUTED;
    ev_qnan_block = 1'b0;
    if (snan) begin
      pre.rep[F_INV] = 1'b1;
      pre.stop       = 1'b1;
      pre.kind       = m_inv ? RK_QNAN_INDEF : RK_KEEP_DEST;
    end else if (qnan) begin
      pre.stop      = 1'b1;
      pre.kind      = RK_COMPUTED;
      ev_qnan_block = div_zero | inv_other | denorm;
    end else if (inv_other) begin
      pre.rep[F_INV] = 1'b1;
      pre.stop       = 1'b1;
      pre.kind       = m_inv ? RK_QNAN_INDEF : RK_KEEP_DEST;
    end else if (div_zero) begin
      pre.rep[F_ZDV] = 1'b1;
      pre.stop       = 1'b1;
      if (m_zdv) begin
        pre.kind = RK_SIGNED_INF;
        pre.sign = inf_sign(sign_a, sign_b);
      end else begin
        pre.kind = RK_KEEP_DEST;
      end
    end else if (denorm) begin
      pre.rep[F_DEN] = 1'b1;
      if (!m_den) begin
        pre.stop = 1'b1;
        pre.kind = RK_KEEP_DEST;
      end
    end
  end

endmodule

// File: rtl/fpx_post_resolve.sv
module fpx_post_resolve
  import fpx_pkg::*;
(
  input  logic             overflow,
  input  logic             tiny,
  input  logic             inexact,
  input  logic             m_unf,
  output logic [NFLAG-1:0] post_rep
);

  always_comb begin
    post_rep = '0;
    if (overflow) begin
      post_rep[F_OVF] = 1'b1;
      post_rep[F_PRE] = inexact;
    end else if (tiny) begin
      post_rep[F_UNF] = underflow_report(tiny, inexact, m_unf);
      post_rep[F_PRE] = inexact;
    end else begin
      post_rep[F_PRE] = inexact;
    end
  end

endmodule

// File: rtl/fpx_sticky.sv
module fpx_sticky #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         upd,
  input  logic [W-1:0] rep,
  output logic [W-1:0] flags
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic set_i;
    assign set_i = upd & rep[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flags[i] <= 1'b0;
      else if (clr) flags[i] <= set_i;
      else          flags[i] <= flags[i] | set_i;
    end
  end

endmodule

// File: rtl/fpx_resolver.sv
module fpx_resolver
  import fpx_pkg::*;
#(
  parameter int FW = NFLAG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_flags,
  input  logic          op_valid,
  input  logic          cnd_snan,
  input  logic          cnd_qnan,
  input  logic          cnd_inv_other,
  input  logic          cnd_div_zero,
  input  logic          cnd_denorm,
  input  logic          cnd_overflow,
  input  logic          cnd_tiny,
  input  logic          cnd_inexact,
  input  logic          sign_a,
  input  logic          sign_b,
  input  logic [FW-1:0] exc_mask,
  output logic [FW-1:0] status_flags,
  output logic          trap_req,
  output logic          res_valid,
  output logic [1:0]    res_kind,
  output logic          res_sign
);

  pre_out_t         pre;
  logic             ev_qnan_block;
  logic [FW-1:0]    post_rep;
  logic [FW-1:0]    op_rep;
  logic             op_trap;
  res_kind_e        op_kind;
  logic             op_sign;

  fpx_pre_resolve u_pre (
    .snan(cnd_snan), .qnan(cnd_qnan), .inv_other(cnd_inv_other),
    .div_zero(cnd_div_zero), .denorm(cnd_denorm),
    .m_inv(exc_mask[F_INV]), .m_den(exc_mask[F_DEN]), .m_zdv(exc_mask[F_ZDV]),
    .sign_a(sign_a), .sign_b(sign_b), .pre(pre), .ev_qnan_block(ev_qnan_block)
  );

  fpx_post_resolve u_post (
    .overflow(cnd_overflow), .tiny(cnd_tiny), .inexact(cnd_inexact),
    .m_unf(exc_mask[F_UNF]), .post_rep(post_rep)
  );

  assign op_rep  = pre.rep | (pre.stop ? '0 : post_rep);
  assign op_kind = pre.kind;
  assign op_sign = pre.sign;
  assign op_trap = any_unmasked(op_rep, exc_mask);

  fpx_sticky #(.W(FW)) u_sticky (
    .clk(clk), .rst_n(rst_n), .clr(clr_flags), .upd(op_valid),
    .rep(op_rep), .flags(status_flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_req  <= 1'b0;
      res_valid <= 1'b0;
      res_kind  <= RK_COMPUTED;
      res_sign  <= 1'b0;
    end else begin
      trap_req  <= op_valid & op_trap;
      res_valid <= op_valid;
      res_kind  <= op_valid ? op_kind : RK_COMPUTED;
      res_sign  <= op_valid & op_sign;
    end
  end

endmodule

// File: rtl/fpx_checker.sv
module fpx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       clr_flags,
  input logic       op_valid,
  input logic       cnd_snan,
  input logic       cnd_qnan,
  input logic       cnd_div_zero,
  input logic [5:0] exc_mask,
  input logic [5:0] status_flags,
  input logic       trap_req,
  input logic [1:0] res_kind,
  input logic       ev_qnan_block
);

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_flags |=> ((status_flags & $past(status_flags)) == $past(status_flags))); // R2

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_flags && !op_valid) |=> (status_flags == 6'd0)); // R3

  AST_SNAN_MASKED_INDEF: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && cnd_snan && exc_mask[0]) |=> (res_kind == 2'd1 && !trap_req)); // R4

  AST_SNAN_UNMASKED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && cnd_snan && !exc_mask[0]) |=> (res_kind == 2'd3 && trap_req)); // R4

  AST_QNAN_HIDES_ZDIV: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && ev_qnan_block && cnd_div_zero && !cnd_snan && !clr_flags && !status_flags[2])
    |=> !status_flags[2]); // R5

  AST_QNAN_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && cnd_qnan && !cnd_snan) |=> !trap_req); // R5

  AST_TRAP_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> $past(op_valid)); // R12

endmodule

bind fpx_resolver fpx_checker u_fpx_checker (
  .clk(clk), .rst_n(rst_n), .clr_flags(clr_flags), .op_valid(op_valid),
  .cnd_snan(cnd_snan), .cnd_qnan(cnd_qnan), .cnd_div_zero(cnd_div_zero),
  .exc_mask(exc_mask), .status_flags(status_flags), .trap_req(trap_req),
  .res_kind(res_kind), .ev_qnan_block(ev_qnan_block)
);

// File: tb/test_fpx_resolver.sv
module test_fpx_resolver;

  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, clr_flags = 0, op_valid = 0;
  logic [7:0] cnd = 0;  // {snan,qnan,inv,zdiv,den,ovf,tiny,inx}
  logic sign_a = 0, sign_b = 0;
  logic [5:0] exc_mask = 0;
  logic [5:0] status_flags;
  logic trap_req, res_valid, res_sign;
  logic [1:0] res_kind;

  int n_chk = 0, n_bad = 0, cyc = 0;
  string phase = "R1";

  logic [5:0] e_flags = 0;
  logic e_trap = 0, e_valid = 0, e_sign = 0;
  logic [1:0] e_kind = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpx_resolver i_fpx_resolver (
    .clk(clk), .rst_n(rst_n), .clr_flags(clr_flags), .op_valid(op_valid),
    .cnd_snan(cnd[7]), .cnd_qnan(cnd[6]), .cnd_inv_other(cnd[5]),
    .cnd_div_zero(cnd[4]), .cnd_denorm(cnd[3]), .cnd_overflow(cnd[2]),
    .cnd_tiny(cnd[1]), .cnd_inexact(cnd[0]), .sign_a(sign_a), .sign_b(sign_b),
    .exc_mask(exc_mask), .status_flags(status_flags), .trap_req(trap_req),
    .res_valid(res_valid), .res_kind(res_kind), .res_sign(res_sign)
  );

  // reference: walks the precedence levels one by one, stopping when a level ends the operation
  function automatic logic [8:0] ref_eval(input logic [7:0] c, input logic [5:0] m,
                                          input logic sa, input logic sb);
    logic [5:0] rep = 0;
    int kind = 0;
    logic sg = 0;
    bit done = 0;
    for (int lvl = 1; lvl <= 6 && !done; lvl++) begin
      case (lvl)
        1: if (c[7]) begin rep[0] = 1; kind = m[0] ? 1 : 3; done = 1; end
        2: if (c[6]) done = 1;
        3: if (c[5]) begin rep[0] = 1; kind = m[0] ? 1 : 3; done = 1; end
           else if (c[4]) begin
             rep[2] = 1; done = 1;
             if (m[2]) begin kind = 2; sg = (sa != sb); end else kind = 3;
           end
        4: if (c[3]) begin rep[1] = 1; if (!m[1]) begin kind = 3; done = 1; end end
        5: if (c[2]) rep[3] = 1;
           else if (c[1]) rep[4] = m[4] ? c[0] : 1'b1;
        6: if (c[0]) rep[5] = 1;
        default: ;
      endcase
    end
    return {kind[1:0], sg, rep};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      e_flags = 0; e_trap = 0; e_valid = 0; e_kind = 0; e_sign = 0;
    end else begin
      logic [8:0] r;
      r = ref_eval(cnd, exc_mask, sign_a, sign_b);
      e_valid = op_valid;
      e_kind  = op_valid ? r[8:7] : 2'd0;
      e_sign  = op_valid ? r[6] : 1'b0;
      e_trap  = op_valid && ((r[5:0] & ~exc_mask) != 0);
      if (clr_flags) e_flags = op_valid ? r[5:0] : 6'd0;
      else if (op_valid) e_flags = e_flags | r[5:0];
    end
  end

  // per-clock comparison with the model
  always @(negedge clk) begin
    if (rst_n) begin
      n_chk++;
      if ({status_flags, trap_req, res_valid, res_kind, res_sign} !==
          {e_flags, e_trap, e_valid, e_kind, e_sign}) begin
        n_bad++;
        $display("FAIL %s cycle %0d: got flags=%b trap=%b v=%b kind=%0d sign=%b exp flags=%b trap=%b v=%b kind=%0d sign=%b",
                 phase, cyc, status_flags, trap_req, res_valid, res_kind, res_sign,
                 e_flags, e_trap, e_valid, e_kind, e_sign);
      end
    end
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic expect_hw(input string tag, input logic [5:0] f, input logic t,
                           input logic [1:0] k, input logic s);
    n_chk++;
    if ({status_flags, trap_req, res_kind, res_sign} !== {f, t, k, s}) begin
      n_bad++;
      $display("FAIL %s: got flags=%b trap=%b kind=%0d sign=%b exp flags=%b trap=%b kind=%0d sign=%b",
               tag, status_flags, trap_req, res_kind, res_sign, f, t, k, s);
    end
  endtask

  task automatic wipe();
    @(negedge clk); clr_flags = 1; op_valid = 0;
    @(negedge clk); clr_flags = 0;
  endtask

  // issue one operation; returns at the negedge where its outcome is visible
  task automatic issue(input logic [7:0] c, input logic [5:0] m, input logic sa, input logic sb);
    @(negedge clk); cnd = c; exc_mask = m; sign_a = sa; sign_b = sb; op_valid = 1;
    @(negedge clk); op_valid = 0; cnd = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    phase = "R1";
    n_chk++;
    if ({status_flags, trap_req, res_valid, res_kind} !== 10'd0) begin
      n_bad++;
      $display("FAIL R1 reset: got %b exp 0", {status_flags, trap_req, res_valid, res_kind});
    end
    rst_n = 1;
    @(negedge clk);

    phase = "R4"; wipe();
    issue(8'b1001_0000, 6'h3F, 0, 0);           // snan + zdiv, all masked
    expect_hw("R4 snan+zdiv masked", 6'b000001, 0, 2'd1, 0);
    wipe(); issue(8'b1000_0000, 6'h3E, 0, 0);
    expect_hw("R4 snan unmasked", 6'b000001, 1, 2'd3, 0);
    @(negedge clk);
    expect_hw("R12 trap single pulse", 6'b000001, 0, 2'd0, 0);

    phase = "R5"; wipe();
    issue(8'b0101_1001, 6'h00, 1, 0);           // qnan + zdiv + den + inx, unmasked
    expect_hw("R5 qnan hides lower", 6'b000000, 0, 2'd0, 0);

    phase = "R6"; wipe();
    issue(8'b0011_0000, 6'h3F, 0, 1);
    expect_hw("R6 invalid beats zdiv", 6'b000001, 0, 2'd1, 0);

    phase = "R7"; wipe();
    issue(8'b0001_0000, 6'h3F, 1, 0);
    expect_hw("R7 masked zdiv sign", 6'b000100, 0, 2'd2, 1);
    wipe(); issue(8'b0001_0000, 6'h3F, 1, 1);
    expect_hw("R7 masked zdiv equal signs", 6'b000100, 0, 2'd2, 0);
    wipe(); issue(8'b0001_0000, 6'h3B, 1, 0);
    expect_hw("R7 unmasked zdiv", 6'b000100, 1, 2'd3, 0);

    phase = "R8"; wipe();
    issue(8'b0000_1101, 6'h3F, 0, 0);           // den + ovf + inx, masked
    expect_hw("R8 masked den passes", 6'b101010, 0, 2'd0, 0);
    wipe(); issue(8'b0000_1101, 6'h3D, 0, 0);
    expect_hw("R8 unmasked den stops", 6'b000010, 1, 2'd3, 0);

    phase = "R9"; wipe();
    issue(8'b0000_0111, 6'h3F, 0, 0);           // ovf + tiny + inx
    expect_hw("R9 ovf over tiny", 6'b101000, 0, 2'd0, 0);
    wipe(); issue(8'b0000_0101, 6'h1F, 0, 0);   // inexact unmasked
    expect_hw("R9 ovf masked pe trap", 6'b101000, 1, 2'd0, 0);

    phase = "R10"; wipe();
    issue(8'b0000_0010, 6'h3F, 0, 0);
    expect_hw("R10 masked tiny exact", 6'b000000, 0, 2'd0, 0);
    wipe(); issue(8'b0000_0011, 6'h3F, 0, 0);
    expect_hw("R10 masked tiny inexact", 6'b110000, 0, 2'd0, 0);
    wipe(); issue(8'b0000_0010, 6'h2F, 0, 0);
    expect_hw("R10 unmasked tiny exact", 6'b010000, 1, 2'd0, 0);

    phase = "R11"; wipe();
    issue(8'b0000_0001, 6'h3F, 0, 0);
    expect_hw("R11 inexact masked", 6'b100000, 0, 2'd0, 0);
    issue(8'b0000_0001, 6'h1F, 0, 0);
    expect_hw("R11 inexact unmasked", 6'b100000, 1, 2'd0, 0);

    phase = "R2";
    issue(8'b0001_0000, 6'h3F, 0, 0);
    expect_hw("R2 accumulate", 6'b100100, 0, 2'd2, 0);

    phase = "R3";
    @(negedge clk); clr_flags = 1; op_valid = 1; cnd = 8'b0000_1000; exc_mask = 6'h3F;
    @(negedge clk); clr_flags = 0; op_valid = 0; cnd = 0;
    expect_hw("R3 clear with strobe", 6'b000010, 0, 2'd0, 0);
    wipe();
    expect_hw("R3 clear alone", 6'b000000, 0, 2'd0, 0);

    phase = "R12 random";
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      op_valid  = ($urandom_range(0, 3) != 0);
      clr_flags = ($urandom_range(0, 15) == 0);
      for (int b = 0; b < 8; b++) cnd[b] = ($urandom_range(0, 3) == 0);
      exc_mask = 6'($urandom());
      sign_a = 1'($urandom()); sign_b = 1'($urandom());
    end
    @(negedge clk); op_valid = 0; clr_flags = 0;
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule